// File: doc/BRIEF.md
# Configuration Watchdog with Reload Trigger

This block supervises a programmable device once its configuration image is running. After the target reports that it has reached user mode, a cycle counter runs on the loader clock. The loaded image must keep the counter from expiring by toggling a heartbeat pin. A new heartbeat level is accepted only after the pin has held it for two consecutive clock cycles. If the counter expires, the block latches an error flag. It also pulses a reload strobe with the factory page (page 0) so that the configuration controller loads the fallback image.

External supervisory logic can start a reload of any stored image. It drives an active-low reload request and supplies a page number. The request, the page bus, the heartbeat and the user-mode status each pass through a two-flop synchronizer. A reload fires on the falling edge of the synchronized request, so holding the request low gives a single strobe. Every port is a plain control or status pin. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `cfg_watchdog`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `wd_error` and `reload_strobe` are 0 and `load_page` is 0.
- R2: The counter does not run while `user_mode` is low. Heartbeat activity that arrives before user mode is seen has no effect on when the later timeout occurs.
- R3: With no heartbeat, `wd_error` rises on the (TIMEOUT_CYCLES+3)-th rising clock edge after `user_mode` goes high. On that same edge, `reload_strobe` pulses with `load_page` = 0.
- R4: A heartbeat level change held for at least two cycles restarts the count from zero. If the pin changes just before the (t+1)-th edge after user mode rose, and t <= TIMEOUT_CYCLES-2, the error moves to edge t+TIMEOUT_CYCLES+5. A restart and an expiry on the same edge resolve in favour of the restart.
- R5: A heartbeat pulse lasting one clock cycle is rejected and does not restart the count.
- R6: Once set, `wd_error` stays high, with no further strobe, until an external reload fires.
- R7: When `reload_n` falls, `reload_strobe` pulses for one cycle on the third edge after the change. `load_page` then shows the 3-bit value of `reload_page_sel` and holds it until the next strobe.
- R8: Holding `reload_n` low gives exactly one strobe, and its rising edge gives none.
- R9: While `wd_enable` is 0, `wd_error` stays 0 and no timeout strobe occurs. When the enable is raised with user mode already present, the error comes TIMEOUT_CYCLES+1 edges later.
- R10: An external reload clears the error and the count and disarms the watchdog. The next arming starts a full fresh period.
- R11: If an external reload and a timeout fall on the same edge, a single strobe carries page 0 and the error is set.
- R12: When `user_mode` goes low, the watchdog disarms and the count is cleared. The next rise of `user_mode` starts a full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loader clock; also the counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wd_enable | input | 1 | Enables the watchdog function |
| user_mode | input | 1 | High while the target runs its loaded image |
| heartbeat | input | 1 | Keep-alive toggle from the loaded image |
| reload_n | input | 1 | Active-low external reload request |
| reload_page_sel | input | PAGE_W (3) | Page to load on an external reload |
| wd_error | output | 1 | Sticky timeout flag, active high |
| reload_strobe | output | 1 | One-cycle reload request to the controller |
| load_page | output | PAGE_W (3) | Page that goes with the last strobe |

## Verification
Each input passes through two synchronizer flops before any decision is made. A reload strobe is therefore due on the third rising edge after `reload_n` changes. An accepted heartbeat clears the count on the fifth edge. The error appears TIMEOUT_CYCLES+3 edges after `user_mode` rises. The bench changes inputs on the falling clock edge and counts rising edges from the moment it drives a stimulus. It samples outputs on the following falling edge and compares the edge index at which each result first appears against the value these formulas give. Sweeps cover every heartbeat arrival time around the expiry edge, pulse widths from one to four cycles, and all eight page values. All of them use a 16-cycle period.

// File: rtl/cfgwd_pkg.sv
package cfgwd_pkg;
  // Origin of a reload request in a given cycle
  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_EXT     = 2'd1,
    SRC_TIMEOUT = 2'd2
  } reload_src_e;
endpackage

// File: rtl/cfgwd_sync.sv
module cfgwd_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfgwd_hb_filter.sv
module cfgwd_hb_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic hb_s,
  output logic kick
);
  logic prev_q;
  logic held_q;
  logic kick_q;

  // A level seen on two consecutive samples that differs from the
  // last accepted level counts as one heartbeat.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      held_q <= 1'b0;
      kick_q <= 1'b0;
    end else begin
      prev_q <= hb_s;
      kick_q <= 1'b0;
      if ((hb_s == prev_q) && (hb_s != held_q)) begin
        held_q <= hb_s;
        kick_q <= 1'b1;
      end
    end
  end

  assign kick = kick_q;
endmodule

// File: rtl/cfgwd_timer.sv
module cfgwd_timer #(
  parameter int PERIOD = 16,
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          um_s,
  input  logic          kick,
  input  logic          ext_fire,
  output logic          timeout,
  output logic          err,
  output logic          armed,
  output logic [CW-1:0] count
);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic          err_q;
  logic          armed_q;
  logic [CW-1:0] count_q;

  assign timeout = armed_q && enable && um_s && !err_q && !kick && (count_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      armed_q <= 1'b0;
      count_q <= '0;
    end else if (timeout) begin
      err_q   <= 1'b1;
      armed_q <= 1'b0;
      count_q <= '0;
    end else if (ext_fire) begin
      err_q   <= 1'b0;
      armed_q <= 1'b0;
      count_q <= '0;
    end else if (!enable || !um_s) begin
      armed_q <= 1'b0;
      count_q <= '0;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      count_q <= '0;
    end else if (err_q || kick) begin
      count_q <= '0;
    end else begin
      count_q <= count_q + CW'(1);
    end
  end

  assign err   = err_q;
  assign armed = armed_q;
  assign count = count_q;
endmodule

// File: rtl/cfgwd_reload.sv
module cfgwd_reload
  import cfgwd_pkg::*;
#(
  parameter int PAGE_W = 3,
  parameter logic [PAGE_W-1:0] FACTORY_PAGE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rn_s,
  input  logic [PAGE_W-1:0] page_s,
  input  logic              timeout,
  output logic              ext_fire,
  output logic              strobe,
  output logic [PAGE_W-1:0] page
);
  logic              rn_prev_q;
  logic              strobe_q;
  logic [PAGE_W-1:0] page_q;
  reload_src_e       src;

  assign ext_fire = rn_prev_q && !rn_s;

  always_comb begin
    if (timeout)       src = SRC_TIMEOUT;
    else if (ext_fire) src = SRC_EXT;
    else               src = SRC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rn_prev_q <= 1'b1;
      strobe_q  <= 1'b0;
      page_q    <= '0;
    end else begin
      rn_prev_q <= rn_s;
      strobe_q  <= (src != SRC_NONE);
      case (src)
        SRC_TIMEOUT: page_q <= FACTORY_PAGE;
        SRC_EXT:     page_q <= page_s;
        default:     page_q <= page_q;
      endcase
    end
  end

  assign strobe = strobe_q;
  assign page   = page_q;
endmodule

// File: rtl/cfg_watchdog.sv
module cfg_watchdog #(
  parameter int TIMEOUT_CYCLES = 16777216,
  parameter int PAGE_W = 3,
  parameter int SYNC_STAGES = 2,
  parameter logic [PAGE_W-1:0] FACTORY_PAGE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wd_enable,
  input  logic              user_mode,
  input  logic              heartbeat,
  input  logic              reload_n,
  input  logic [PAGE_W-1:0] reload_page_sel,
  output logic              wd_error,
  output logic              reload_strobe,
  output logic [PAGE_W-1:0] load_page
);
  localparam int CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam int REQ_W = PAGE_W + 1;

  logic [1:0]       stat_s;
  logic [REQ_W-1:0] req_s;
  logic             kick;
  logic             timeout;
  logic             ext_fire;
  logic             err_q;
  logic             armed_q;
  logic [CNT_W-1:0] count_q;

  cfgwd_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_stat (
    .clk(clk), .rst_n(rst_n),
    .d({user_mode, heartbeat}),
    .q(stat_s)
  );

  cfgwd_sync #(.W(REQ_W), .STAGES(SYNC_STAGES), .RST_VAL({1'b1, {PAGE_W{1'b0}}})) u_sync_req (
    .clk(clk), .rst_n(rst_n),
    .d({reload_n, reload_page_sel}),
    .q(req_s)
  );

  cfgwd_hb_filter u_hb (
    .clk(clk), .rst_n(rst_n),
    .hb_s(stat_s[0]),
    .kick(kick)
  );

  cfgwd_timer #(.PERIOD(TIMEOUT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .enable(wd_enable),
    .um_s(stat_s[1]),
    .kick(kick),
    .ext_fire(ext_fire),
    .timeout(timeout),
    .err(err_q),
    .armed(armed_q),
    .count(count_q)
  );

  cfgwd_reload #(.PAGE_W(PAGE_W), .FACTORY_PAGE(FACTORY_PAGE)) u_reload (
    .clk(clk), .rst_n(rst_n),
    .rn_s(req_s[REQ_W-1]),
    .page_s(req_s[PAGE_W-1:0]),
    .timeout(timeout),
    .ext_fire(ext_fire),
    .strobe(reload_strobe),
    .page(load_page)
  );

  assign wd_error = err_q && wd_enable;
endmodule

// File: rtl/cfg_watchdog_chk.sv
module cfg_watchdog_chk #(
  parameter int PERIOD = 16,
  parameter int PAGE_W = 3,
  parameter int CW = 4,
  parameter logic [PAGE_W-1:0] FACTORY_PAGE = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wd_enable,
  input logic              wd_error,
  input logic              reload_strobe,
  input logic [PAGE_W-1:0] load_page,
  input logic              err_q,
  input logic              armed_q,
  input logic [CW-1:0]     count_q,
  input logic              kick,
  input logic              ext_fire,
  input logic              timeout
);
  // R3
  timeout_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (reload_strobe && load_page == FACTORY_PAGE));

  // R3
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(PERIOD - 1));

  // R4
  kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (count_q == '0));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_q) |-> $past(ext_fire));

  // R9
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_enable |-> !wd_error);

  // R10
  disarmed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> (count_q == '0));

  // R7
  ext_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_fire && !timeout) |=> (reload_strobe && !err_q));
endmodule

bind cfg_watchdog cfg_watchdog_chk #(
  .PERIOD(TIMEOUT_CYCLES), .PAGE_W(PAGE_W), .CW(CNT_W), .FACTORY_PAGE(FACTORY_PAGE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wd_enable(wd_enable), .wd_error(wd_error),
  .reload_strobe(reload_strobe), .load_page(load_page),
  .err_q(err_q), .armed_q(armed_q), .count_q(count_q),
  .kick(kick), .ext_fire(ext_fire), .timeout(timeout)
);

// File: tb/test_cfg_watchdog.sv
module test_cfg_watchdog;
  localparam int P = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wd_enable = 1'b1;
  logic       user_mode = 1'b0;
  logic       heartbeat = 1'b0;
  logic       reload_n = 1'b1;
  logic [2:0] reload_page_sel = 3'd0;
  logic       wd_error;
  logic       reload_strobe;
  logic [2:0] load_page;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cfg_watchdog #(.TIMEOUT_CYCLES(P), .PAGE_W(3)) i_cfg_watchdog (
    .clk(clk), .rst_n(rst_n), .wd_enable(wd_enable), .user_mode(user_mode),
    .heartbeat(heartbeat), .reload_n(reload_n), .reload_page_sel(reload_page_sel),
    .wd_error(wd_error), .reload_strobe(reload_strobe), .load_page(load_page)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wd_enable = 1'b1; user_mode = 1'b0; heartbeat = 1'b0;
    reload_n = 1'b1; reload_page_sel = 3'd0;
    repeat (3) tick();
    rst_n = 1'b1;
  endtask

  // Counts edges until wd_error is seen high; returns limit+1 if never.
  task automatic wait_err(input int start, input int limit, output int n);
    n = start;
    while (n <= limit) begin
      tick();
      n++;
      if (wd_error) return;
    end
    n = limit + 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    int strobes;

    // R1: reset state
    apply_reset();
    chk(!wd_error && !reload_strobe && load_page == 0, "R1 reset outputs",
        {wd_error, reload_strobe, load_page}, 0);

    // R2: no user mode, no counting
    heartbeat = 1'b0;
    strobes = 0;
    for (int i = 0; i < 3*P; i++) begin tick(); if (wd_error || reload_strobe) strobes++; end
    chk(strobes == 0, "R2 idle without user mode", strobes, 0);

    // R2: heartbeat before arming has no effect on expiry time
    apply_reset();
    heartbeat = 1'b1;
    repeat (10) tick();
    user_mode = 1'b1;
    wait_err(0, 4*P, n);
    chk(n == P + 3, "R2 pre-arm heartbeat ignored", n, P + 3);

    // R3/R4: sweep heartbeat arrival time
    for (int t = 0; t <= P + 2; t++) begin
      int exp;
      apply_reset();
      user_mode = 1'b1;
      exp = (t <= P - 2) ? (t + 5 + P) : (P + 3);
      n = 0;
      while (n < 4*P) begin
        if (n == t) heartbeat = 1'b1;
        tick();
        n++;
        if (wd_error) break;
      end
      chk(n == exp, (t > P - 2) ? "R3 expiry edge" : "R4 heartbeat restart", n, exp);
      chk(reload_strobe && load_page == 0, "R3 factory strobe", {reload_strobe, load_page}, 8);
    end

    // R5/R4: pulse width sweep
    for (int w = 1; w <= 4; w++) begin
      int exp;
      apply_reset();
      user_mode = 1'b1;
      exp = (w == 1) ? (P + 3) : (4 + w + 5 + P);
      n = 0;
      while (n < 4*P) begin
        if (n == 4) heartbeat = 1'b1;
        if (n == 4 + w) heartbeat = 1'b0;
        tick();
        n++;
        if (wd_error) break;
      end
      chk(n == exp, (w == 1) ? "R5 glitch rejected" : "R4 pulse accepted", n, exp);
    end

    // R7/R8: external reload for every page
    for (int p = 0; p < 8; p++) begin
      apply_reset();
      reload_n = 1'b0;
      reload_page_sel = 3'(p);
      strobes = 0;
      for (int k = 1; k <= 12; k++) begin
        tick();
        if (reload_strobe) strobes++;
        if (k == 2) chk(!reload_strobe, "R7 strobe not early", reload_strobe, 0);
        if (k == 3) chk(reload_strobe && load_page == 3'(p), "R7 strobe with page",
                        {reload_strobe, load_page}, 8 + p);
        if (k == 4) chk(!reload_strobe, "R7 single-cycle strobe", reload_strobe, 0);
      end
      reload_n = 1'b1;
      reload_page_sel = 3'(~p);
      repeat (6) begin tick(); if (reload_strobe) strobes++; end
      chk(strobes == 1, "R8 one strobe per press", strobes, 1);
      chk(load_page == 3'(p), "R7 page held", load_page, p);
    end

    // R6/R10: sticky error, cleared by external reload, fresh period
    apply_reset();
    user_mode = 1'b1;
    wait_err(0, 4*P, n);
    strobes = 0;
    for (int k = 0; k < 40; k++) begin
      tick();
      if (reload_strobe) strobes++;
      if (!wd_error) strobes += 100;
    end
    chk(strobes == 0, "R6 error sticky, no repeat strobe", strobes, 0);
    user_mode = 1'b0;
    reload_n = 1'b0;
    reload_page_sel = 3'd3;
    repeat (3) tick();
    chk(!wd_error && reload_strobe && load_page == 3, "R10 external reload clears error",
        {wd_error, reload_strobe, load_page}, 11);
    reload_n = 1'b1;
    repeat (2) tick();
    user_mode = 1'b1;
    wait_err(0, 4*P, n);
    chk(n == P + 3, "R10 fresh period after reload", n, P + 3);

    // R9: disabled
    apply_reset();
    wd_enable = 1'b0;
    user_mode = 1'b1;
    strobes = 0;
    for (int k = 0; k < 3*P; k++) begin tick(); if (wd_error || reload_strobe) strobes++; end
    chk(strobes == 0, "R9 disabled stays quiet", strobes, 0);
    wd_enable = 1'b1;
    wait_err(0, 4*P, n);
    chk(n == P + 1, "R9 enable starts period", n, P + 1);

    // R11: simultaneous external reload and timeout
    apply_reset();
    user_mode = 1'b1;
    n = 0;
    while (n < P + 3) begin
      if (n == P) begin reload_n = 1'b0; reload_page_sel = 3'd5; end
      tick();
      n++;
    end
    chk(reload_strobe && load_page == 0 && wd_error, "R11 timeout wins",
        {wd_error, reload_strobe, load_page}, 12);
    tick();
    chk(!reload_strobe && wd_error, "R11 single strobe", {wd_error, reload_strobe}, 2);
    reload_n = 1'b1;

    // R12: user mode drop clears count
    apply_reset();
    user_mode = 1'b1;
    n = 0;
    while (n < 4*P) begin
      if (n == 10) user_mode = 1'b0;
      if (n == 14) user_mode = 1'b1;
      tick();
      n++;
      if (wd_error) break;
    end
    chk(n == 14 + 3 + P, "R12 disarm on user mode loss", n, 14 + 3 + P);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule